// File: doc/BRIEF.md
# Coprocessor Region Load Controller

This block sits between a processor and a small pool of reconfigurable regions, each able to host one coprocessor image at a time. The processor raises a select request carrying a coprocessor identifier. The block checks its allocation table, which records for each region whether it is occupied, which identifier it holds, whether the processor has dismissed that identifier, and how recently the region was selected. A resident identifier is acknowledged on the next cycle.

On a miss, the identifier is placed in a small queue of scheduled loads. A requester stage takes it from the queue and chooses a target region. It looks up the image start address and word count for the identifier and pulses a start strobe to an external streaming engine. When the engine reports completion, the table is updated and the processor is acknowledged. Until then, further select requests are ignored. Dismissal hints from the processor can arrive at any time and steer where the next load goes.

Top module: `copro_region_mgr`

## Requirements
- R1: After reset no region is occupied, and `sel_ack` and `load_start` are low.
- R2: A select request for an identifier held by a region raises `sel_ack` in the following cycle and causes no `load_start`.
- R3: A select request for a non-resident identifier raises `load_start` for exactly one cycle, two cycles after the request is sampled. In that cycle `load_addr` = IMG_BASE + id*IMG_STRIDE and `load_len` = IMG_LEN0 + id*IMG_LEN_STEP.
- R4: For a load, `sel_ack` is a single-cycle pulse in the cycle after `load_done` is sampled high. It stays low from the request until then.
- R5: The load target is the lowest-numbered unoccupied region when one exists.
- R6: With no unoccupied region, the lowest-numbered dismissed region is chosen ahead of any other.
- R7: With no unoccupied or eligible dismissed region, the least recently selected region is chosen. A region counts as selected on a hit or on completion of a load into it.
- R8: The most recently selected region is never a load target, even when it is dismissed.
- R9: While a load is pending (from the missing request until its acknowledge), `sel_req` is ignored and produces no acknowledge.
- R10: After a load completes, the region holds the new identifier and later requests for it hit. The identifier it held before no longer hits.
- R11: A `drop_req` marks the region holding `drop_id` as dismissed. A later hit on that region clears the mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_req | input | 1 | Select request from the processor, one cycle per request |
| sel_id | input | IDW | Identifier of the requested coprocessor |
| drop_req | input | 1 | Dismissal hint strobe |
| drop_id | input | IDW | Identifier being dismissed |
| sel_ack | output | 1 | Single-cycle acknowledge of a select request |
| load_start | output | 1 | Single-cycle strobe starting the streaming engine |
| load_addr | output | AW | Image start address in configuration memory |
| load_len | output | LW | Image length in words |
| load_region | output | RW | Target region of the load |
| load_done | input | 1 | Streaming engine completion pulse |

## Verification
The embedded assertions watch properties that hold on every cycle. The acknowledge and start strobes never last two cycles. The load target is never the current region. No acknowledge appears while a load is pending without a completion. A resident request is always acknowledged next cycle, and the scheduled-load queue never overflows. Region choice is a different matter: which region wins among free, dismissed and least recently selected candidates depends on the history of hits, loads and hints. Only the bench's scenarios show it, by building specific table states and then reading `load_region`, the lookup outputs and the acknowledge timing.

// File: rtl/copro_region_mgr.sv
module copro_region_mgr #(
  parameter int NREG         = 2,
  parameter int NID          = 8,
  parameter int AW           = 16,
  parameter int LW           = 12,
  parameter int QD           = 2,
  parameter int IMG_BASE     = 0,
  parameter int IMG_STRIDE   = 256,
  parameter int IMG_LEN0     = 16,
  parameter int IMG_LEN_STEP = 4,
  localparam int IDW = $clog2(NID),
  localparam int RW  = $clog2(NREG),
  localparam int QAW = $clog2(QD)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sel_req,
  input  logic [IDW-1:0] sel_id,
  input  logic           drop_req,
  input  logic [IDW-1:0] drop_id,
  output logic           sel_ack,
  output logic           load_start,
  output logic [AW-1:0]  load_addr,
  output logic [LW-1:0]  load_len,
  output logic [RW-1:0]  load_region,
  input  logic           load_done
);

  logic [NREG-1:0] vld, rmv;
  logic [IDW-1:0]  own [NREG];
  logic [RW-1:0]   age [NREG];
  logic            cur_vld;
  logic [RW-1:0]   cur;
  logic            busy, loading;
  logic [RW-1:0]   tgt;
  logic [IDW-1:0]  tgt_id;

  logic [IDW-1:0]  q [QD];
  logic [QAW-1:0]  wp, rp;
  logic [QAW:0]    qcnt;

  logic            hit;
  logic [RW-1:0]   hit_idx;
  logic            free_f, rm_f;
  logic [RW-1:0]   free_idx, rm_idx, lru_idx, victim;
  logic [RW-1:0]   lru_age;

  wire accept = sel_req && !busy;
  wire push   = accept && !hit;
  wire pop    = (qcnt != 0) && !loading;
  wire fin    = loading && load_done;
  wire sel_ev = (accept && hit) || fin;
  wire [RW-1:0]  sel_r = fin ? tgt : hit_idx;
  wire [IDW-1:0] pid   = q[rp];

  always_comb begin
    hit = 1'b0; hit_idx = '0;
    free_f = 1'b0; free_idx = '0;
    rm_f = 1'b0; rm_idx = '0;
    lru_idx = '0; lru_age = '0;
    for (int i = NREG-1; i >= 0; i--) begin
      if (vld[i] && own[i] == sel_id) begin hit = 1'b1; hit_idx = RW'(i); end
      if (!vld[i]) begin free_f = 1'b1; free_idx = RW'(i); end
      if (vld[i] && rmv[i] && !(cur_vld && cur == RW'(i))) begin rm_f = 1'b1; rm_idx = RW'(i); end
    end
    for (int i = 0; i < NREG; i++)
      if (!(cur_vld && cur == RW'(i)) && age[i] >= lru_age) begin lru_age = age[i]; lru_idx = RW'(i); end
    victim = free_f ? free_idx : (rm_f ? rm_idx : lru_idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0; rmv <= '0;
      for (int i = 0; i < NREG; i++) begin own[i] <= '0; age[i] <= RW'(i); end
      for (int i = 0; i < QD; i++) q[i] <= '0;
      cur_vld <= 1'b0; cur <= '0;
      busy <= 1'b0; loading <= 1'b0; tgt <= '0; tgt_id <= '0;
      wp <= '0; rp <= '0; qcnt <= '0;
      sel_ack <= 1'b0; load_start <= 1'b0;
      load_addr <= '0; load_len <= '0; load_region <= '0;
    end else begin
      sel_ack    <= sel_ev;
      load_start <= pop;
      qcnt       <= qcnt + (QAW+1)'(push) - (QAW+1)'(pop);
      if (push) begin
        busy  <= 1'b1;
        q[wp] <= sel_id;
        wp    <= (wp == QAW'(QD-1)) ? '0 : wp + 1'b1;
      end
      if (pop) begin
        rp          <= (rp == QAW'(QD-1)) ? '0 : rp + 1'b1;
        loading     <= 1'b1;
        tgt         <= victim;
        tgt_id      <= pid;
        load_region <= victim;
        load_addr   <= AW'(IMG_BASE + int'(pid) * IMG_STRIDE);
        load_len    <= LW'(IMG_LEN0 + int'(pid) * IMG_LEN_STEP);
      end
      if (drop_req)
        for (int i = 0; i < NREG; i++)
          if (vld[i] && own[i] == drop_id) rmv[i] <= 1'b1;
      if (sel_ev) begin
        cur_vld    <= 1'b1;
        cur        <= sel_r;
        rmv[sel_r] <= 1'b0;
        for (int i = 0; i < NREG; i++)
          if (age[i] < age[sel_r]) age[i] <= age[i] + 1'b1;
        age[sel_r] <= '0;
      end
      if (fin) begin
        loading  <= 1'b0;
        busy     <= 1'b0;
        vld[tgt] <= 1'b1;
        own[tgt] <= tgt_id;
      end
    end
  end

  a_r4_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ack |=> !sel_ack);
  a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |=> !load_start);
  a_r8_not_current: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |-> !(cur_vld && load_region == cur));
  a_r9_no_early_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load_done) |=> !sel_ack);
  a_r2_hit_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_req && !busy && hit) |=> (sel_ack && !load_start));
  a_r3_queue_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (qcnt < (QAW+1)'(QD)));

endmodule

// File: tb/tb_copro_region_mgr.sv
module tb_copro_region_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 3, NID = 8, AW = 16, LW = 12;
  localparam int BASE = 'h100, STRIDE = 'h40, LEN0 = 4, STEP = 2;
  localparam int IDW = 3, RW = 2;

  logic clk = 0, rst_n = 0;
  logic sel_req = 0, drop_req = 0, load_done = 0;
  logic [IDW-1:0] sel_id = '0, drop_id = '0;
  logic sel_ack, load_start;
  logic [AW-1:0] load_addr;
  logic [LW-1:0] load_len;
  logic [RW-1:0] load_region;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  copro_region_mgr #(.NREG(NREG), .NID(NID), .AW(AW), .LW(LW), .QD(2),
    .IMG_BASE(BASE), .IMG_STRIDE(STRIDE), .IMG_LEN0(LEN0), .IMG_LEN_STEP(STEP)) dut (
    .clk(clk), .rst_n(rst_n), .sel_req(sel_req), .sel_id(sel_id),
    .drop_req(drop_req), .drop_id(drop_id), .sel_ack(sel_ack),
    .load_start(load_start), .load_addr(load_addr), .load_len(load_len),
    .load_region(load_region), .load_done(load_done));

  // vector: [7] drop, [6:4] id, [3] expect hit, [1:0] expected region on a miss
  localparam int NV = 17;
  localparam logic [7:0] VEC [NV] = '{
    8'b0_001_0_0_00, // R5 free r0
    8'b0_010_0_0_01, // R5 free r1
    8'b0_011_0_0_10, // R5 free r2
    8'b0_010_1_0_00, // R2 hit
    8'b0_100_0_0_00, // R7 LRU r0
    8'b1_010_0_0_00, // R11 drop id2
    8'b0_101_0_0_01, // R6 dismissed r1 over LRU r2
    8'b0_011_1_0_00, // R2 hit r2
    8'b1_011_0_0_00, // drop current
    8'b0_110_0_0_00, // R8 current r2 skipped -> r0
    8'b0_101_1_0_00, // hit r1
    8'b0_100_0_0_10, // R10 id4 evicted -> dismissed r2
    8'b1_110_0_0_00, // R11 drop id6 (r0)
    8'b0_110_1_0_00, // R11 hit clears mark
    8'b0_101_1_0_00, // hit r1
    8'b0_111_0_0_10, // R11 LRU r2, not r0
    8'b0_010_0_0_00  // R10 old id2 gone -> r0
  };

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_drop(input logic [IDW-1:0] id);
    @(negedge clk); drop_req = 1; drop_id = id;
    @(negedge clk); drop_req = 0;
  endtask

  task automatic do_sel(input logic [IDW-1:0] id, input bit exp_hit,
                        input logic [RW-1:0] exp_reg, input bit poke);
    @(negedge clk); sel_req = 1; sel_id = id;
    @(negedge clk); sel_req = 0;
    if (exp_hit) begin
      chk(sel_ack == 1, "R2 ack", sel_ack, 1);
      chk(load_start == 0, "R2 no start", load_start, 0);
      @(negedge clk);
      chk(sel_ack == 0, "R2 ack pulse", sel_ack, 0);
    end else begin
      chk(sel_ack == 0, "R4 no early ack", sel_ack, 0);
      chk(load_start == 0, "R3 start timing", load_start, 0);
      @(negedge clk);
      chk(load_start == 1, "R3 start", load_start, 1);
      chk(load_addr == AW'(BASE + int'(id) * STRIDE), "R3 addr", load_addr, BASE + int'(id) * STRIDE);
      chk(load_len == LW'(LEN0 + int'(id) * STEP), "R3 len", load_len, LEN0 + int'(id) * STEP);
      chk(load_region == exp_reg, "R5 R6 R7 R8 region", load_region, exp_reg);
      for (int k = 0; k < 3; k++) begin
        if (poke && k == 0) begin sel_req = 1; sel_id = 3'd5; end
        @(negedge clk);
        sel_req = 0;
        chk(sel_ack == 0, poke ? "R9 ignored" : "R4 ack wait", sel_ack, 0);
        chk(load_start == 0, "R3 start pulse", load_start, 0);
      end
      load_done = 1;
      @(negedge clk); load_done = 0;
      chk(sel_ack == 1, "R4 ack after done", sel_ack, 1);
      @(negedge clk);
      chk(sel_ack == 0, "R4 ack single", sel_ack, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sel_ack == 0, "R1 ack", sel_ack, 0);
    chk(load_start == 0, "R1 start", load_start, 0);
    rst_n = 1;
    @(negedge clk);
    chk(sel_ack == 0 && load_start == 0, "R1 idle", {sel_ack, load_start}, 0);
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][7]) do_drop(VEC[v][6:4]);
      else do_sel(VEC[v][6:4], VEC[v][3], VEC[v][1:0], 1'b0);
    end
    // R9: request for resident id5 during a load is dropped; victim r1 is LRU
    do_sel(3'd0, 1'b0, 2'd1, 1'b1);
    do_sel(3'd5, 1'b0, 2'd2, 1'b0); // R10 id5 was evicted by the previous load
    do_sel(3'd0, 1'b1, 2'd0, 1'b0); // R10 new id resident
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule